// File: doc/BRIEF.md
# Signed Binary to Packed Decimal Converter

The converter takes a 128-bit two's-complement integer and produces a 128-bit packed decimal word. The word holds 31 magnitude digits, most significant digit in the top nibble, with a sign code in the lowest nibble. The block also produces a four-bit condition code. The code classifies the result against zero and flags operands whose magnitude cannot be written in 31 digits.

The engine is sequential. A start pulse captures the operand and the sign preference. One setup cycle then forms the absolute value and range-checks it. After that, 128 shift-and-adjust cycles move the magnitude into decimal one bit at a time, and a single-cycle done pulse marks the new outputs. The interface has no back-pressure. A start pulse seen while a conversion is running is dropped rather than queued. A caller must wait for done before it issues the next start. Result and condition code are registered and keep their values until the next conversion completes.

Top module: `bcd_from_sq`

## Requirements
- R1: For an in-range operand, result nibbles 31 down to 1 hold the decimal digits of the magnitude, most significant first, and each digit is at most 9.
- R2: A negative operand produces sign nibble 0xD in result bits [3:0].
- R3: A non-negative operand produces sign nibble 0xC when pos_sign_sel is 0 and 0xF when it is 1.
- R4: The magnitude is the full 128-bit two's-complement negation of a negative operand, so an all-ones operand converts to digit value 1.
- R5: When the magnitude exceeds 10^31-1 (including the most negative 128-bit value), cond is 4'b0001, all digit nibbles are zero and the sign nibble follows R2/R3.
- R6: For an in-range operand, cond bit 3 is set for a negative nonzero value, bit 2 for a positive nonzero value and bit 1 for zero, with exactly one of these set and bit 0 clear.
- R7: done is high for exactly one cycle, 129 clock edges after the edge that accepted start (one setup cycle plus 128 shift cycles).
- R8: A start pulse while a conversion is in progress is ignored. Neither its operand nor a change of pos_sign_sel affects the running conversion.
- R9: After reset, result, cond and done are zero. result and cond change only on the cycle done rises and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion when idle |
| op_in | input | 128 | Two's-complement operand, sampled with start |
| pos_sign_sel | input | 1 | Sign code choice for non-negative results (0: 0xC, 1: 0xF) |
| result | output | 128 | Packed decimal: 31 digits over a sign nibble |
| cond | output | 4 | {LT, GT, EQ, SO} condition code |
| done | output | 1 | One-cycle pulse when result and cond are updated |

## Verification
The reference model in the bench goes after the sign-magnitude edges: -1 and all-ones inputs catch a design that negates only the upper half, because such a design reports a magnitude around 2^64 instead of 1. The values ±(10^31-1) and ±10^31 sit on either side of the range limit. A check confined to the upper 64 bits, or an off-by-one compare, lets 10^31 through with digits or flags 10^31-1 as overflow. The most negative value, whose negation is itself, must land in overflow and not be read as positive. A second start issued mid-run with a different operand and sign preference shows whether a design restarts or recaptures while busy.

// File: rtl/bcdq_pkg.sv
package bcdq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT
  } conv_state_t;

  localparam logic [3:0] SIGN_NEG     = 4'hD;
  localparam logic [3:0] SIGN_POS_STD = 4'hC;
  localparam logic [3:0] SIGN_POS_ALT = 4'hF;

  // Largest magnitude representable with n decimal digits, 256-bit wide.
  function automatic logic [255:0] dec_max(input int n);
    logic [255:0] v;
    v = 256'd1;
    for (int i = 0; i < n; i++) v = v * 256'd10;
    return v - 256'd1;
  endfunction

  // Condition code {LT, GT, EQ, SO}.
  function automatic logic [3:0] make_cond(input logic neg, input logic ovf,
                                           input logic zero);
    if (ovf)       return 4'b0001;
    else if (zero) return 4'b0010;
    else if (neg)  return 4'b1000;
    else           return 4'b0100;
  endfunction

  // True when digit nibbles 1..n of a packed word are all valid decimal.
  function automatic logic digits_ok(input logic [255:0] w, input int n);
    logic ok;
    ok = 1'b1;
    for (int i = 1; i <= n; i++) begin
      if (w[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/bcdq_prep.sv
module bcdq_prep #(
  parameter int OP_W = 128,
  parameter logic [OP_W-1:0] LIMIT = '1
) (
  input  logic [OP_W-1:0] op,
  input  logic            psel,
  output logic [OP_W-1:0] mag,
  output logic            neg,
  output logic            ovf,
  output logic [3:0]      sign_nib
);
  import bcdq_pkg::*;

  always_comb begin
    neg      = op[OP_W-1];
    mag      = neg ? (~op + {{(OP_W-1){1'b0}}, 1'b1}) : op;
    ovf      = (mag > LIMIT);
    sign_nib = neg ? SIGN_NEG : (psel ? SIGN_POS_ALT : SIGN_POS_STD);
  end

endmodule

// File: rtl/bcdq_dabble.sv
module bcdq_dabble #(
  parameter int OP_W   = 128,
  parameter int DIGITS = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  step,
  input  logic [OP_W-1:0]       mag_in,
  output logic [4*DIGITS-1:0]   bcd_next,
  output logic                  spill
);
  localparam int BCD_W = 4 * DIGITS;

  logic [OP_W-1:0]  sh_q;
  logic [BCD_W-1:0] bcd_q;
  logic [BCD_W-1:0] adj;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] d;
    assign d = bcd_q[4*g +: 4];
    assign adj[4*g +: 4] = (d >= 4'd5) ? (d + 4'd3) : d;
  end

  assign bcd_next = {adj[BCD_W-2:0], sh_q[OP_W-1]};
  assign spill    = adj[BCD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bcd_q <= '0;
    end else if (load) begin
      sh_q  <= mag_in;
      bcd_q <= '0;
    end else if (step) begin
      sh_q  <= {sh_q[OP_W-2:0], 1'b0};
      bcd_q <= bcd_next;
    end
  end

  // R1: digits of the running value stay decimal while no digit spills out
  p_digit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step && !spill |=> bcdq_pkg::digits_ok({128'b0, bcd_q, 4'b0}, DIGITS));

endmodule

// File: rtl/bcd_from_sq.sv
module bcd_from_sq #(
  parameter int OP_W   = 128,
  parameter int DIGITS = 31
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [OP_W-1:0]           op_in,
  input  logic                      pos_sign_sel,
  output logic [4*(DIGITS+1)-1:0]   result,
  output logic [3:0]                cond,
  output logic                      done
);
  import bcdq_pkg::*;

  localparam int RES_W = 4 * (DIGITS + 1);
  localparam int BCD_W = 4 * DIGITS;
  localparam int CNT_W = $clog2(OP_W);
  localparam logic [255:0]    LIM_WIDE = dec_max(DIGITS);
  localparam logic [OP_W-1:0] LIMIT    = LIM_WIDE[OP_W-1:0];
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(OP_W - 1);

  conv_state_t      state;
  logic [OP_W-1:0]  op_q;
  logic             ps_q;
  logic             neg_q, ovf_q;
  logic [3:0]       sign_q;
  logic [CNT_W-1:0] cnt;

  logic [OP_W-1:0]  mag;
  logic             neg, ovf;
  logic [3:0]       sign_nib;
  logic [BCD_W-1:0] bcd_next;
  logic             spill;
  logic             ovf_all;

  bcdq_prep #(.OP_W(OP_W), .LIMIT(LIMIT)) u_prep (
    .op       (op_q),
    .psel     (ps_q),
    .mag      (mag),
    .neg      (neg),
    .ovf      (ovf),
    .sign_nib (sign_nib)
  );

  bcdq_dabble #(.OP_W(OP_W), .DIGITS(DIGITS)) u_dabble (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state == ST_SETUP),
    .step     (state == ST_SHIFT),
    .mag_in   (mag),
    .bcd_next (bcd_next),
    .spill    (spill)
  );

  assign ovf_all = ovf_q | spill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= '0;
      ps_q   <= 1'b0;
      neg_q  <= 1'b0;
      ovf_q  <= 1'b0;
      sign_q <= 4'h0;
      cnt    <= '0;
      result <= '0;
      cond   <= 4'h0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            op_q  <= op_in;
            ps_q  <= pos_sign_sel;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          neg_q  <= neg;
          ovf_q  <= ovf;
          sign_q <= sign_nib;
          cnt    <= '0;
          state  <= ST_SHIFT;
        end
        ST_SHIFT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            result <= ovf_all ? {{BCD_W{1'b0}}, sign_q} : {bcd_next, sign_q};
            cond   <= make_cond(neg_q, ovf_all, bcd_next == '0);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: once shifting, the engine runs to its last step regardless of start
  p_busy_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT) && (cnt != LAST) |=> (state == ST_SHIFT));

  // R9: outputs move only together with done
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result) && $stable(cond));

  // R2: a less-than result carries the negative sign code
  p_neg_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && cond[3] |-> result[3:0] == SIGN_NEG);

  // R6: an in-range result sets exactly one comparison flag
  p_cc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cond[0] |-> $countones(cond[3:1]) == 1);

  // R5: overflow clears the digits and the comparison flags
  p_no_overflow_digits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && cond[0] |-> (result[RES_W-1:4] == '0) && (cond[3:1] == 3'b000));

  // R1: an in-range result holds only decimal digits
  p_digits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cond[0] |-> digits_ok(256'(result), DIGITS));

endmodule

// File: tb/test_bcd_from_sq.sv
module test_bcd_from_sq;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [127:0] op_in;
  logic         pos_sign_sel;
  logic [127:0] result;
  logic [3:0]   cond;
  logic         done;

  always #5 clk = ~clk;

  bcd_from_sq i_bcd_from_sq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in),
    .pos_sign_sel(pos_sign_sel), .result(result), .cond(cond), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [127:0] limit;
  bit           m_busy = 0;
  int           m_cnt = 0;
  bit           exp_done = 0;
  logic [127:0] exp_res = '0;
  logic [3:0]   exp_cc = '0;
  logic [127:0] pend_res;
  logic [3:0]   pend_cc;
  string        pend_tag = "R1";
  string        next_tag = "R1";
  string        done_tag = "R1";

  task automatic check(input string tag, input logic [127:0] act,
                       input logic [127:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [127:0] op, input logic ps,
                                output logic [127:0] res, output logic [3:0] cc);
    logic         neg;
    logic [127:0] m;
    logic [3:0]   sgn;
    neg = op[127];
    m   = neg ? (128'd0 - op) : op;
    sgn = neg ? 4'hD : (ps ? 4'hF : 4'hC);
    res = '0;
    res[3:0] = sgn;
    if (m > limit) begin
      cc = 4'b0001;
    end else begin
      cc = (m == 0) ? 4'b0010 : (neg ? 4'b1000 : 4'b0100);
      for (int k = 1; k <= 31; k++) begin
        res[4*k +: 4] = 4'(m % 128'd10);
        m = m / 128'd10;
      end
    end
  endfunction

  // Behavioural cycle model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; exp_done = 0; exp_res = '0; exp_cc = '0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      exp_done = 0;
      if (was_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          exp_done = 1; exp_res = pend_res; exp_cc = pend_cc;
          done_tag = pend_tag; m_busy = 0;
        end
      end
      if (start && !was_busy) begin
        model(op_in, pos_sign_sel, pend_res, pend_cc);
        pend_tag = next_tag;
        m_busy = 1;
        m_cnt  = 129;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7", {127'b0, done}, {127'b0, exp_done}, "done");
      check(exp_done ? done_tag : "R9", result, exp_res, "result");
      check(exp_done ? done_tag : "R9", {124'b0, cond}, {124'b0, exp_cc}, "cond");
    end
  end

  task automatic run_op(input logic [127:0] op, input logic ps, input string tag);
    while (m_busy) @(negedge clk);
    next_tag = tag;
    op_in = op; pos_sign_sel = ps; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [127:0] r;
    limit = 128'd1;
    repeat (31) limit = limit * 128'd10;
    limit = limit - 128'd1;
    rst_n = 1'b0; start = 1'b0; op_in = '0; pos_sign_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", result, '0, "reset result");
    check("R9", {124'b0, cond}, '0, "reset cond");
    check("R9", {127'b0, done}, '0, "reset done");
    rst_n = 1'b1;
    @(negedge clk);

    run_op(128'd0, 1'b0, "R6");
    run_op(128'd0, 1'b1, "R3");
    run_op(128'd1, 1'b0, "R3");
    run_op('1, 1'b0, "R4");                       // all ones = -1
    run_op(128'd1234567890123, 1'b1, "R1");
    run_op(128'd0 - 128'd987654321, 1'b0, "R2");
    run_op(limit, 1'b1, "R1");
    run_op(128'd0 - limit, 1'b0, "R2");
    run_op(limit + 128'd1, 1'b0, "R5");
    run_op(128'd0 - (limit + 128'd1), 1'b1, "R5");
    run_op({1'b1, 127'b0}, 1'b0, "R5");           // most negative
    run_op({1'b0, {127{1'b1}}}, 1'b1, "R5");
    run_op({64'h0000_0000_0000_0001, 64'h0}, 1'b0, "R4");
    run_op(128'd0 - {64'h1, 64'h0}, 1'b0, "R4");

    // R8: second start mid-run with other operand and sign choice is dropped
    while (m_busy) @(negedge clk);
    next_tag = "R8";
    op_in = 128'd4242; pos_sign_sel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    next_tag = "R8";
    op_in = 128'd0 - 128'd77; pos_sign_sel = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);

    // Random operands: in-range and full-width
    for (int n = 0; n < 24; n++) begin
      r = {$urandom, $urandom, $urandom, $urandom};
      if (n % 2 == 0) begin
        r = r & {28'h0, {100{1'b1}}};
        if (n % 4 == 0) r = 128'd0 - r;
      end
      run_op(r, n[2], "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule